// File: doc/BRIEF.md
# Up-Counting Timer with One Output-Compare Channel

This block is a register-programmed timer for use as a system tick or event source. A counter of fixed width (16 or 32 bits, chosen by parameter) counts upward on a clock enable. The enable comes from a power-of-two prescaler. The counter wraps at a programmable terminal count and raises an overflow flag when it does.

One compare channel watches the counter. When the channel is armed in software-compare mode, it raises a flag on the increment where the count equals its compare value. The single interrupt line reports that flag, gated by the channel's enable bit.

Software reaches all state over a plain 32-bit word bus with 8-bit byte offsets. Reads are combinational. Writes take effect on the rising clock edge where the enable and write strobes are both high. Both flags are cleared by writing a 1 to them. The channel flag can also be cleared, and read, through a shared status word.

Top module: `tmr_cmp_top`

## Requirements
- R1: The word at offset 0x04 returns the counter width in bits 23:16 (0x10 for a 16-bit build, 0x20 for a 32-bit build) and 0 in all other bits; writes to it have no effect.
- R2: After reset every readable word except the one at 0x04 reads 0, and `irq` is low.
- R3: In the control word at 0x10, bits 2:0 hold a prescale exponent N and bit 3 is the run bit. While run is 1 the count advances once every 2^N clock cycles: the first advance is 2^N edges after the edge that set run. While run is 0 the count holds.
- R4: Any write to offset 0x14 (the count word) sets the count to 0 and restarts the prescale phase, whatever data is written. Reading 0x14 returns the current count.
- R5: Offset 0x18 holds the terminal count. On an advance where the count equals it, the count becomes 0 and the overflow flag (bit 7 of 0x10) sets. On every other advance the count grows by one.
- R6: Writing 1 to bit 7 of 0x10 clears the overflow flag, and writing 0 there leaves it unchanged. If the flag sets in the same cycle as a clear, the flag ends up set.
- R7: The channel control word at 0x20 holds a mode in bits 5:2. With mode 4 (software compare), an advance on which the count equals the compare word at 0x24 sets the channel flag (bit 7 of 0x20). With any other mode the flag never sets.
- R8: Writing 1 to bit 7 of 0x20, or to bit 0 of 0x1C, clears the channel flag. Writing 0 to those bits leaves it unchanged. Bit 0 of 0x1C reads the channel flag. If the flag sets in the same cycle as a clear, the flag ends up set.
- R9: `irq` is high exactly when the channel flag is set and bit 6 of 0x20 (channel interrupt enable) is 1.
- R10: The count, terminal-count and compare words read 0 in every bit at or above the counter width.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the bus and the counter |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_en | input | 1 | Access strobe |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 8 | Byte offset of the word |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from `bus_addr` |
| irq | output | 1 | Channel interrupt request |

## Verification
Two events can land on the same clock edge: a hardware flag set (a wrap for the overflow flag, a compare match for the channel flag) and a software write-one-to-clear of that flag. The bench counts edges from the write that starts the counter. It then times a clearing write so that it arrives on the exact edge where the count reaches the terminal or compare value. In both cases the flag must read as set afterwards. Separate directed writes of 0 and of 1 confirm that a clear on its own edge behaves as described.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

   // byte offsets of the register words
   localparam logic [7:0] OFS_INFO   = 8'h04;
   localparam logic [7:0] OFS_CTL    = 8'h10;
   localparam logic [7:0] OFS_COUNT  = 8'h14;
   localparam logic [7:0] OFS_TERM   = 8'h18;
   localparam logic [7:0] OFS_STAT   = 8'h1C;
   localparam logic [7:0] OFS_CHCTL  = 8'h20;
   localparam logic [7:0] OFS_CHVAL  = 8'h24;

   // prescale exponent field and phase counter
   localparam int PSC_W   = 3;
   localparam int PHASE_W = (1 << PSC_W) - 1;

   // control word bit positions
   localparam int CTL_RUN_BIT = 3;
   localparam int CTL_OVF_BIT = 7;

   // channel word bit positions
   localparam int CH_MODE_LSB = 2;
   localparam int CH_MODE_W   = 4;
   localparam int CH_IE_BIT   = 6;
   localparam int CH_FLG_BIT  = 7;

   localparam logic [CH_MODE_W-1:0] MODE_SWCMP = 4'h4;

   // position of the width field in the info word
   localparam int INFO_W_LSB = 16;

endpackage

// File: rtl/tmr_prescale.sv
module tmr_prescale
   import tmr_pkg::*;
#(
   parameter int EXP_W = PSC_W
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run,
   input  logic             restart,
   input  logic [EXP_W-1:0] exponent,
   output logic             tick
);

   localparam int PH_W = (1 << EXP_W) - 1;

   logic [PH_W-1:0] phase_q;
   logic [PH_W-1:0] mask;

   assign mask = PH_W'((33'd1 << exponent) - 33'd1);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase_q <= '0;
      end else if (!run || restart) begin
         phase_q <= '0;
      end else begin
         phase_q <= phase_q + 1'b1;
      end
   end

   assign tick = run && ((phase_q & mask) == mask);

endmodule

// File: rtl/tmr_counter.sv
module tmr_counter #(
   parameter int CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick,
   input  logic             zero,
   input  logic [CNT_W-1:0] term,
   input  logic             ovf_clr,
   output logic [CNT_W-1:0] count,
   output logic             ovf
);

   logic at_term;
   logic wrap;

   assign at_term = (count == term);
   assign wrap    = tick && at_term;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         count <= '0;
      end else if (zero) begin
         count <= '0;
      end else if (tick) begin
         count <= at_term ? '0 : count + 1'b1;
      end
   end

   // a set on the same edge beats a clear
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ovf <= 1'b0;
      end else if (wrap) begin
         ovf <= 1'b1;
      end else if (ovf_clr) begin
         ovf <= 1'b0;
      end
   end

endmodule

// File: rtl/tmr_channel.sv
module tmr_channel
   import tmr_pkg::*;
#(
   parameter int CNT_W = 16
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 tick,
   input  logic [CNT_W-1:0]     count,
   input  logic                 ctl_wr,
   input  logic                 val_wr,
   input  logic                 stat_wr,
   input  logic [31:0]          wdata,
   output logic [CH_MODE_W-1:0] mode,
   output logic                 ie,
   output logic [CNT_W-1:0]     cmp,
   output logic                 flag
);

   logic hit;
   logic clr;

   assign hit = tick && (mode == MODE_SWCMP) && (count == cmp);
   assign clr = (ctl_wr  && wdata[CH_FLG_BIT]) ||
                (stat_wr && wdata[0]);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mode <= '0;
         ie   <= 1'b0;
      end else if (ctl_wr) begin
         mode <= wdata[CH_MODE_LSB +: CH_MODE_W];
         ie   <= wdata[CH_IE_BIT];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cmp <= '0;
      end else if (val_wr) begin
         cmp <= wdata[CNT_W-1:0];
      end
   end

   // a match on the same edge beats a clear
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         flag <= 1'b0;
      end else if (hit) begin
         flag <= 1'b1;
      end else if (clr) begin
         flag <= 1'b0;
      end
   end

endmodule

// File: rtl/tmr_cmp_top.sv
module tmr_cmp_top
   import tmr_pkg::*;
#(
   parameter int CNT_W = 16
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        bus_en,
   input  logic        bus_we,
   input  logic [7:0]  bus_addr,
   input  logic [31:0] bus_wdata,
   output logic [31:0] bus_rdata,
   output logic        irq
);

   localparam logic [7:0] WIDTH_CODE = 8'(CNT_W);

   generate
      if (CNT_W != 16 && CNT_W != 32) begin : g_bad_width
         $error("tmr_cmp_top: CNT_W must be 16 or 32");
      end
   endgenerate

   // write strobes
   logic wr;
   logic wr_ctl, wr_cnt, wr_term, wr_stat, wr_chctl, wr_chval;

   assign wr       = bus_en && bus_we;
   assign wr_ctl   = wr && (bus_addr == OFS_CTL);
   assign wr_cnt   = wr && (bus_addr == OFS_COUNT);
   assign wr_term  = wr && (bus_addr == OFS_TERM);
   assign wr_stat  = wr && (bus_addr == OFS_STAT);
   assign wr_chctl = wr && (bus_addr == OFS_CHCTL);
   assign wr_chval = wr && (bus_addr == OFS_CHVAL);

   // control word state
   logic             run;
   logic [PSC_W-1:0] psc;
   logic [CNT_W-1:0] term;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         run <= 1'b0;
         psc <= '0;
      end else if (wr_ctl) begin
         run <= bus_wdata[CTL_RUN_BIT];
         psc <= bus_wdata[PSC_W-1:0];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         term <= '0;
      end else if (wr_term) begin
         term <= bus_wdata[CNT_W-1:0];
      end
   end

   logic                 tick;
   logic [CNT_W-1:0]     count;
   logic                 ovf;
   logic [CH_MODE_W-1:0] ch_mode;
   logic                 ch_ie;
   logic [CNT_W-1:0]     ch_cmp;
   logic                 ch_flag;

   tmr_prescale #(.EXP_W(PSC_W)) u_psc (
      .clk      (clk),
      .rst_n    (rst_n),
      .run      (run),
      .restart  (wr_cnt),
      .exponent (psc),
      .tick     (tick)
   );

   tmr_counter #(.CNT_W(CNT_W)) u_cnt (
      .clk     (clk),
      .rst_n   (rst_n),
      .tick    (tick),
      .zero    (wr_cnt),
      .term    (term),
      .ovf_clr (wr_ctl && bus_wdata[CTL_OVF_BIT]),
      .count   (count),
      .ovf     (ovf)
   );

   tmr_channel #(.CNT_W(CNT_W)) u_ch0 (
      .clk     (clk),
      .rst_n   (rst_n),
      .tick    (tick),
      .count   (count),
      .ctl_wr  (wr_chctl),
      .val_wr  (wr_chval),
      .stat_wr (wr_stat),
      .wdata   (bus_wdata),
      .mode    (ch_mode),
      .ie      (ch_ie),
      .cmp     (ch_cmp),
      .flag    (ch_flag)
   );

   // width-dependent zero extension of counter-sized words
   logic [31:0] count_x, term_x, cmp_x;

   generate
      if (CNT_W == 32) begin : g_full
         assign count_x = count;
         assign term_x  = term;
         assign cmp_x   = ch_cmp;
      end else begin : g_narrow
         logic unused_hi;
         assign unused_hi = ^bus_wdata[31:CNT_W];
         assign count_x   = {{(32-CNT_W){1'b0}}, count};
         assign term_x    = {{(32-CNT_W){1'b0}}, term};
         assign cmp_x     = {{(32-CNT_W){1'b0}}, ch_cmp};
      end
   endgenerate

   always_comb begin
      bus_rdata = '0;
      unique case (bus_addr)
         OFS_INFO:  bus_rdata[INFO_W_LSB +: 8] = WIDTH_CODE;
         OFS_CTL: begin
            bus_rdata[PSC_W-1:0]   = psc;
            bus_rdata[CTL_RUN_BIT] = run;
            bus_rdata[CTL_OVF_BIT] = ovf;
         end
         OFS_COUNT: bus_rdata = count_x;
         OFS_TERM:  bus_rdata = term_x;
         OFS_STAT:  bus_rdata[0] = ch_flag;
         OFS_CHCTL: begin
            bus_rdata[CH_MODE_LSB +: CH_MODE_W] = ch_mode;
            bus_rdata[CH_IE_BIT]  = ch_ie;
            bus_rdata[CH_FLG_BIT] = ch_flag;
         end
         OFS_CHVAL: bus_rdata = cmp_x;
         default:   bus_rdata = '0;
      endcase
   end

   assign irq = ch_flag && ch_ie;

endmodule

// File: rtl/tmr_cmp_chk.sv
module tmr_cmp_chk
   import tmr_pkg::*;
#(
   parameter int CNT_W = 16
) (
   input logic                 clk,
   input logic                 rst_n,
   input logic                 wr_cnt,
   input logic                 wr_ctl,
   input logic                 clr_bit,
   input logic                 tick,
   input logic                 run,
   input logic [CNT_W-1:0]     count,
   input logic [CNT_W-1:0]     term,
   input logic                 ovf,
   input logic [CH_MODE_W-1:0] mode,
   input logic                 flag
);

   // R4
   count_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wr_cnt |=> (count == '0));

   // R5
   wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (tick && (count == term) && !wr_cnt) |=> ((count == '0) && ovf));

   // R3
   hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!run && !wr_cnt) |=> $stable(count));

   // R7
   mode_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ((mode != MODE_SWCMP) && !flag) |=> !flag);

   // R6
   ovf_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_ctl && clr_bit && !(tick && (count == term))) |=> !ovf);

endmodule

bind tmr_cmp_top tmr_cmp_chk #(.CNT_W(CNT_W)) u_chk (
   .clk     (clk),
   .rst_n   (rst_n),
   .wr_cnt  (wr_cnt),
   .wr_ctl  (wr_ctl),
   .clr_bit (bus_wdata[7]),
   .tick    (tick),
   .run     (run),
   .count   (count),
   .term    (term),
   .ovf     (ovf),
   .mode    (ch_mode),
   .flag    (ch_flag)
);

// File: tb/tmr_cmp_top_tb_top.sv
`timescale 1ns/1ps
module tmr_cmp_top_tb_top;

   localparam int W = 16;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_en = 1'b0;
   logic        bus_we = 1'b0;
   logic [7:0]  bus_addr = '0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic        irq;

   int checks = 0;
   int errors = 0;
   bit done = 0;

   always #4 clk = ~clk;

   tmr_cmp_top #(.CNT_W(W)) dut_i (
      .clk(clk), .rst_n(rst_n), .bus_en(bus_en), .bus_we(bus_we),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata),
      .bus_rdata(bus_rdata), .irq(irq)
   );

   // called at a falling edge; the write lands on the next rising edge
   task automatic wr(input logic [7:0] a, input logic [31:0] d);
      bus_en = 1; bus_we = 1; bus_addr = a; bus_wdata = d;
      @(posedge clk);
      @(negedge clk);
      bus_en = 0; bus_we = 0;
   endtask

   task automatic rd(input logic [7:0] a, output logic [31:0] d);
      bus_en = 1; bus_we = 0; bus_addr = a;
      #1;
      d = bus_rdata;
      bus_en = 0;
   endtask

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
      end
   endtask

   // reference model: k edges after the starting edge
   function automatic int exp_count(int k, int p, int m);
      return (k >> p) % (m + 1);
   endfunction
   function automatic bit exp_ovf(int k, int p, int m);
      return (k >> p) > m;
   endfunction
   function automatic bit exp_flag(int k, int p, int c, int md);
      return (md == 4) && ((k >> p) > c);
   endfunction

   task automatic quiesce();
      wr(8'h10, 32'h0);
      wr(8'h10, 32'h80);
      wr(8'h20, 32'h80);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         checks++; errors++;
         $display("FAIL watchdog actual=hung expected=finished");
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      logic [31:0] d;
      void'($urandom(32'd2024));
      repeat (3) @(negedge clk);
      rst_n = 1;
      @(negedge clk);

      // R2 reset state
      foreach (dut_i.bus_rdata[i]) ; // no-op
      rd(8'h10, d); chk("R2 ctl", d, 0);
      rd(8'h14, d); chk("R2 count", d, 0);
      rd(8'h18, d); chk("R2 term", d, 0);
      rd(8'h1C, d); chk("R2 stat", d, 0);
      rd(8'h20, d); chk("R2 chctl", d, 0);
      rd(8'h24, d); chk("R2 chval", d, 0);
      chk("R2 irq", {31'b0, irq}, 0);

      // R1 info word and write ignored
      rd(8'h04, d); chk("R1 width", d, 32'h0010_0000);
      wr(8'h04, 32'hFFFF_FFFF);
      rd(8'h04, d); chk("R1 write ignored", d, 32'h0010_0000);

      // R10 upper bits read zero
      wr(8'h18, 32'hFFFF_FFFF);
      rd(8'h18, d); chk("R10 term", d, 32'h0000_FFFF);
      wr(8'h24, 32'hABCD_FFFF);
      rd(8'h24, d); chk("R10 chval", d, 32'h0000_FFFF);

      // R3 R5 R7 R9 random runs against the model
      for (int it = 0; it < 24; it++) begin
         int p, m, c, md, ie, k;
         p  = $urandom % 4;
         m  = 3 + ($urandom % 30);
         c  = $urandom % (m + 1);
         md = ($urandom % 2) ? 4 : ($urandom % 16);
         ie = $urandom % 2;
         k  = $urandom % 200;
         quiesce();
         wr(8'h18, m);
         wr(8'h24, c);
         wr(8'h20, (md << 2) | (ie << 6));
         wr(8'h14, 32'h5A5A);
         wr(8'h10, 32'h8 | p);
         repeat (k) @(posedge clk);
         @(negedge clk);
         rd(8'h14, d); chk("R3 R5 count", d, exp_count(k, p, m));
         rd(8'h10, d); chk("R5 ovf", {31'b0, d[7]}, exp_ovf(k, p, m));
         rd(8'h1C, d); chk("R7 R8 stat flag", d, exp_flag(k, p, c, md));
         chk("R9 irq", {31'b0, irq}, exp_flag(k, p, c, md) && ie);
      end

      // R3 hold while stopped
      quiesce();
      wr(8'h18, 32'hFFFF);
      wr(8'h14, 0);
      wr(8'h10, 32'h8);
      repeat (9) @(negedge clk);
      wr(8'h10, 32'h0);
      rd(8'h14, d);
      begin
         logic [31:0] held;
         held = d;
         repeat (20) @(negedge clk);
         rd(8'h14, d); chk("R3 hold", d, held);
      end

      // R4 write of any value zeros a running count
      wr(8'h10, 32'h8);
      repeat (30) @(negedge clk);
      wr(8'h14, 32'h1234);
      rd(8'h14, d); chk("R4 zero on write", d, 0);

      // R6 write-zero keeps, write-one clears overflow
      quiesce();
      wr(8'h18, 3);
      wr(8'h14, 0);
      wr(8'h10, 32'h8);
      repeat (10) @(negedge clk);
      wr(8'h10, 32'h0);
      rd(8'h10, d); chk("R6 ovf set", {31'b0, d[7]}, 1);
      wr(8'h10, 32'h0);
      rd(8'h10, d); chk("R6 write 0 keeps", {31'b0, d[7]}, 1);
      wr(8'h10, 32'h80);
      rd(8'h10, d); chk("R6 write 1 clears", {31'b0, d[7]}, 0);

      // R8 both clear paths
      wr(8'h18, 32'hFFFF);
      wr(8'h24, 2);
      wr(8'h20, 32'h50);
      wr(8'h14, 0);
      wr(8'h10, 32'h8);
      repeat (6) @(negedge clk);
      wr(8'h10, 32'h0);
      rd(8'h20, d); chk("R8 flag set", {31'b0, d[7]}, 1);
      chk("R9 irq high", {31'b0, irq}, 1);
      wr(8'h1C, 32'h0);
      rd(8'h1C, d); chk("R8 stat write 0 keeps", d, 1);
      wr(8'h1C, 32'h1);
      rd(8'h1C, d); chk("R8 stat clear", d, 0);
      chk("R9 irq low", {31'b0, irq}, 0);
      wr(8'h14, 0);
      wr(8'h10, 32'h8);
      repeat (6) @(negedge clk);
      wr(8'h10, 32'h0);
      wr(8'h20, 32'hD0);
      rd(8'h20, d); chk("R8 chctl clear", d, 32'h50);

      // R8 collision: match and status clear on the same edge
      quiesce();
      wr(8'h18, 20);
      wr(8'h24, 5);
      wr(8'h20, 32'h50);
      wr(8'h14, 0);
      wr(8'h10, 32'h8);
      repeat (5) @(negedge clk);
      wr(8'h1C, 32'h1);
      rd(8'h1C, d); chk("R8 set beats clear", d, 1);

      // R6 collision: wrap and overflow clear on the same edge
      quiesce();
      wr(8'h18, 7);
      wr(8'h14, 0);
      wr(8'h10, 32'h8);
      repeat (7) @(negedge clk);
      wr(8'h10, 32'h88);
      rd(8'h10, d); chk("R6 set beats clear", {31'b0, d[7]}, 1);

      done = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule